// File: doc/BRIEF.md
# Shadow-Sample Timing Warning Detector Array

This block surrounds a group of critical-path endpoint registers and raises an early warning when their timing margin runs out. Each endpoint keeps a main register that does exactly what the original register did. Next to it sits a shadow register that takes the same data at a later moment. If the two captured values disagree, data arrived late. Because the shadow register sees the late data first, the warning comes before the main register goes wrong.

The block has two detector styles. In the tap style, the shadow register runs on the main clock and samples a late copy of the data (`ep_late`). In the phase style, the shadow register samples the endpoint's own data on a second clock (`clk_phase`). That clock has the same frequency but a later phase, which suits endpoints whose real capture point cannot be observed, such as memory inputs.

Each per-endpoint mismatch goes through a synchronizer chain. The results are then OR-combined into one activation output for a clock/voltage controller. They are also summed into a saturating activation counter that the controller can clear.

Top module: `tvd_array`

## Requirements
- R1: `ep_q` equals the `ep_d` value present at the previous `clk` rising edge. This holds whatever the values of `ep_late`, `clk_phase` and `det_en`.
- R2: Tap-style endpoints are indices 0 to N_TAP-1. Endpoint i uses `ep_d[i*W +: W]` and `ep_late[i*W +: W]`. Suppose both slices are captured at `clk` edge E0 and differ in any bit. Then `act_vec[i]` is 1 from edge E0+SYNC_STAGES until the following edge, which is exactly one cycle. It is 0 at every other time.
- R3: Phase-style endpoints are indices N_TAP to N_EP-1. Suppose an endpoint's `ep_d` slice changes after `clk` edge E0 but before the following `clk_phase` rising edge. Then that endpoint's `act_vec` bit is 1 for exactly one cycle, starting at edge E0+SYNC_STAGES.
- R4: When main and shadow captures agree, `act_vec` stays 0. This covers a tap endpoint whose late copy equals its data, and a phase endpoint whose data is stable across both clock edges.
- R5: While `det_en` is 0, `act_vec` and `act_any` are 0 and the count does not change. No activation held in the pipeline appears after `det_en` returns to 1.
- R6: `act_any` is 1 exactly when at least one bit of `act_vec` is 1.
- R7: At each `clk` edge with `cnt_clr` low, `act_cnt` increases by the number of 1 bits in `act_vec`.
- R8: `act_cnt` saturates at 2^CNT_W-1 and never wraps.
- R9: When `cnt_clr` is 1 at a `clk` edge, `act_cnt` becomes 0. Any activations in that same cycle are dropped.
- R10: While `rst_n` is low at a `clk` edge, `ep_q`, `act_vec`, `act_any` and `act_cnt` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for endpoints, synchronizers and counter |
| clk_phase | input | 1 | Same-frequency, later-phase clock for phase-style shadow registers |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Detector enable; 0 forces all activations to 0 |
| cnt_clr | input | 1 | Synchronous clear of the activation count |
| ep_d | input | N_EP*W | Endpoint data inputs, W bits per endpoint |
| ep_late | input | N_TAP*W | Late copy of the tap-style endpoint data (slow route) |
| ep_q | output | N_EP*W | Main register outputs, functional path |
| act_vec | output | N_EP | Synchronized per-endpoint activation |
| act_any | output | 1 | OR of all activations |
| act_cnt | output | CNT_W | Saturating activation count |

## Verification
Every single bit of every endpoint of both styles is disturbed in turn. Every subset of endpoints is then fired together.

The bench checks that the activation appears in exactly one cycle, SYNC_STAGES edges late, and on the right bit. It would catch a shortened or lengthened synchronizer, a style wired to the wrong clock or data, or a lane swap.

The count is driven past its ceiling, and a clear is made to coincide with a live activation. A wrapping counter or an increment that wins over the clear would show up there.

Detections are injected with the enable low and then the enable is raised. A pipeline that leaks stale activations, or a main register that follows the late copy, shows up as wrong outputs.

// File: rtl/tvd_pkg.sv
// Package: shared types for the timing warning detector array.
// Assumes: nothing beyond IEEE 1800-2017.
package tvd_pkg;
    // Detector style: delayed data tap on the main clock, or a phase-shifted clock.
    typedef enum logic {
        STYLE_TAP   = 1'b0,
        STYLE_PHASE = 1'b1
    } det_style_e;
endpackage

// File: rtl/tvd_sync.sv
// Module: tvd_sync
// Carries a raw mismatch flag through STAGES flops into the clk domain.
// Assumes: STAGES >= 1. A low en clears the chain and forces the output low.
module tvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // First stage: capture the gated mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din & en;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages: shift, cleared while disabled.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1] & en;
            end
        end
    endgenerate

    assign dout = chain[STAGES-1] & en;
endmodule

// File: rtl/tvd_shadow_reg.sv
// Module: tvd_shadow_reg
// Shadow capture register. The parent picks its clock and data source.
// Assumes: rst_n is usable on whichever clock drives clk_s.
module tvd_shadow_reg #(
    parameter int W = 4
) (
    input  logic         clk_s,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the late-arriving view of the endpoint data.
    always_ff @(posedge clk_s) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tvd_cell.sv
// Module: tvd_cell
// One endpoint: the functional main register, the mismatch compare against
// the shadow capture, and the synchronizer on the result.
// Assumes: shadow_q comes from a tvd_shadow_reg sampling later than clk.
module tvd_cell #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    input  logic [W-1:0] shadow_q,
    output logic [W-1:0] q,
    output logic         act
);
    logic miss;

    // Main register: the original functional behaviour, untouched by detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Any differing bit between main and shadow is one warning.
    always_comb miss = |(q ^ shadow_q);

    tvd_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .din  (miss),
        .dout (act)
    );
endmodule

// File: rtl/tvd_act_count.sv
// Module: tvd_act_count
// Adds the number of active detectors each cycle into a saturating count.
// Assumes: N <= 2**CNT_W - 1, so a single cycle's sum fits the count range.
module tvd_act_count #(
    parameter int N     = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N-1:0]     hits,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = $clog2(N + 1);

    logic [SUM_W-1:0] sum;
    logic [CNT_W:0]   ext;

    // Population count of this cycle's activations.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) sum = sum + SUM_W'(hits[i]);
    end

    // Widened add so that overflow shows in the top bit.
    always_comb ext = {1'b0, cnt} + {{(CNT_W + 1 - SUM_W){1'b0}}, sum};

    // Count register: clear wins, then saturating accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (ext[CNT_W]) cnt <= '1;
        else                 cnt <= ext[CNT_W-1:0];
    end
endmodule

// File: rtl/tvd_array.sv
// Module: tvd_array (top)
// Array of timing warning detectors around critical endpoints. Endpoints
// 0..N_TAP-1 use a delayed-data shadow on clk. The rest use a shadow on
// clk_phase. Warnings are OR-combined and counted.
// Assumes: clk_phase has clk's frequency and a later phase; rst_n is synchronous.
module tvd_array #(
    parameter int N_TAP       = 3,
    parameter int N_PHASE     = 2,
    parameter int W           = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  clk_phase,
    input  logic                                  rst_n,
    input  logic                                  det_en,
    input  logic                                  cnt_clr,
    input  logic [(N_TAP+N_PHASE)*W-1:0]          ep_d,
    input  logic [((N_TAP > 0) ? N_TAP : 1)*W-1:0] ep_late,
    output logic [(N_TAP+N_PHASE)*W-1:0]          ep_q,
    output logic [N_TAP+N_PHASE-1:0]              act_vec,
    output logic                                  act_any,
    output logic [CNT_W-1:0]                      act_cnt
);
    import tvd_pkg::*;

    localparam int N_EP = N_TAP + N_PHASE;

    logic [N_EP*W-1:0] shadow_q;

    genvar i;
    generate
        for (i = 0; i < N_EP; i++) begin : g_ep
            localparam det_style_e STYLE = (i < N_TAP) ? STYLE_TAP : STYLE_PHASE;

            if (STYLE == STYLE_TAP) begin : g_tap
                tvd_shadow_reg #(.W(W)) u_shadow (
                    .clk_s(clk),
                    .rst_n(rst_n),
                    .d    (ep_late[i*W +: W]),
                    .q    (shadow_q[i*W +: W])
                );
            end else begin : g_phase
                tvd_shadow_reg #(.W(W)) u_shadow (
                    .clk_s(clk_phase),
                    .rst_n(rst_n),
                    .d    (ep_d[i*W +: W]),
                    .q    (shadow_q[i*W +: W])
                );
            end

            tvd_cell #(.W(W), .STAGES(SYNC_STAGES)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (det_en),
                .d       (ep_d[i*W +: W]),
                .shadow_q(shadow_q[i*W +: W]),
                .q       (ep_q[i*W +: W]),
                .act     (act_vec[i])
            );
        end
    endgenerate

    // Single warning line for the controller.
    always_comb act_any = |act_vec;

    tvd_act_count #(.N(N_EP), .CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .hits (act_vec),
        .cnt  (act_cnt)
    );
endmodule

// File: rtl/tvd_array_chk.sv
// Module: tvd_array_chk
// Port-level temporal checks for tvd_array, attached through bind.
// Assumes: sampled on clk; the bind passes the top's parameters.
module tvd_array_chk #(
    parameter int N_EP  = 5,
    parameter int W     = 4,
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              det_en,
    input logic              cnt_clr,
    input logic [N_EP*W-1:0] ep_d,
    input logic [N_EP*W-1:0] ep_q,
    input logic [N_EP-1:0]   act_vec,
    input logic              act_any,
    input logic [CNT_W-1:0]  act_cnt
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ep_q == $past(ep_d));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> (act_vec == '0) && !act_any);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> act_cnt == '0);

    // R7
    count_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && (int'(act_cnt) + $countones(act_vec) <= CNT_MAX))
        |=> int'(act_cnt) == int'($past(act_cnt)) + $countones($past(act_vec)));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && (int'(act_cnt) + $countones(act_vec) > CNT_MAX))
        |=> int'(act_cnt) == CNT_MAX);
endmodule

bind tvd_array tvd_array_chk #(.N_EP(N_EP), .W(W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .det_en (det_en),
    .cnt_clr(cnt_clr),
    .ep_d   (ep_d),
    .ep_q   (ep_q),
    .act_vec(act_vec),
    .act_any(act_any),
    .act_cnt(act_cnt)
);

// File: tb/tvd_array_tb_top.sv
`timescale 1ns/100ps
module tvd_array_tb_top;
    localparam int NT   = 3;
    localparam int NP   = 2;
    localparam int NE   = NT + NP;
    localparam int WB   = 4;
    localparam int CW   = 4;
    localparam int SMAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              clk_phase = 1'b0;
    logic              rst_n = 1'b0;
    logic              det_en = 1'b0;
    logic              cnt_clr = 1'b0;
    logic [NE*WB-1:0]  ep_d = '0;
    logic [NT*WB-1:0]  ep_late = '0;
    logic [NE*WB-1:0]  ep_q;
    logic [NE-1:0]     act_vec;
    logic              act_any;
    logic [CW-1:0]     act_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_model = 0;

    tvd_array #(.N_TAP(NT), .N_PHASE(NP), .W(WB), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .clk_phase(clk_phase), .rst_n(rst_n), .det_en(det_en),
        .cnt_clr(cnt_clr), .ep_d(ep_d), .ep_late(ep_late), .ep_q(ep_q),
        .act_vec(act_vec), .act_any(act_any), .act_cnt(act_cnt)
    );

    always #5 clk = ~clk;

    // Phase clock: same period, 2.5 ns after each clk rise.
    always @(posedge clk) begin
        #2.5 clk_phase = 1'b1;
        #5   clk_phase = 1'b0;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [NE-1:0] m);
        int c = 0;
        for (int i = 0; i < NE; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic clear_count();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        cnt_model = 0;
        chk("R9 clear", 64'(act_cnt), 64'(0));
    endtask

    // Inject a mismatch on bit b of each endpoint in mask; expect expm to fire.
    task automatic fire(input logic [NE-1:0] mask, input int b,
                        input logic [NE-1:0] expm, input bit clr_hit);
        logic [NE*WB-1:0] cap;
        for (int i = 0; i < NT; i++)
            if (mask[i]) ep_late[i*WB + b] = ~ep_d[i*WB + b];
        cap = ep_d;
        @(posedge clk);                       // E0
        #1;
        for (int i = NT; i < NE; i++)
            if (mask[i]) ep_d[i*WB + b] = ~ep_d[i*WB + b];
        ep_late = ep_d[NT*WB-1:0];
        @(negedge clk);
        chk("R1 main ignores late copy", 64'(ep_q), 64'(cap));
        chk("R4 no early activation", 64'(act_vec), 64'(0));
        @(negedge clk);                       // after E1
        chk("R4 no activation before latency", 64'(act_vec), 64'(0));
        @(negedge clk);                       // after E2
        chk("R2/R3 activation vector", 64'(act_vec), 64'(expm));
        chk("R6 combined activation", 64'(act_any), 64'(|expm));
        if (clr_hit) cnt_clr = 1'b1;
        @(negedge clk);                       // after E3
        cnt_clr = 1'b0;
        chk("R2/R3 one-cycle activation", 64'(act_vec), 64'(0));
        if (clr_hit) cnt_model = 0;
        else         cnt_model = (cnt_model + popc(expm) > SMAX) ? SMAX : cnt_model + popc(expm);
        chk("R7/R8/R9 count", 64'(act_cnt), 64'(cnt_model));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [NE*WB-1:0] prev;
        ep_d = 20'h5A5A5;
        ep_late = ep_d[NT*WB-1:0];
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ep_q reset", 64'(ep_q), 64'(0));
        chk("R10 act reset", 64'({act_any, act_vec}), 64'(0));
        chk("R10 count reset", 64'(act_cnt), 64'(0));
        rst_n = 1'b1;
        det_en = 1'b1;
        @(negedge clk);

        // R1/R4: functional pass-through with agreeing captures
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ep_d = {lfsr[3:0], lfsr};
            ep_late = ep_d[NT*WB-1:0];
            prev = ep_d;
            @(negedge clk);
            chk("R1 pass-through", 64'(ep_q), 64'(prev));
            chk("R4 quiet on agreement", 64'(act_vec), 64'(0));
        end
        repeat (3) @(negedge clk);
        clear_count();

        // R2/R3: every bit of every endpoint alone
        for (int e = 0; e < NE; e++)
            for (int b = 0; b < WB; b++) begin
                fire(NE'(1 << e), b, NE'(1 << e), 1'b0);
                if (cnt_model >= 10) clear_count();
            end

        // R6/R7: every subset fired together
        for (int m = 1; m < (1 << NE); m++) begin
            clear_count();
            fire(NE'(m), m % WB, NE'(m), 1'b0);
        end

        // R8: drive past the ceiling
        clear_count();
        for (int k = 0; k < 4; k++) fire('1, k, '1, 1'b0);
        chk("R8 saturated", 64'(act_cnt), 64'(SMAX));

        // R9: clear coinciding with an activation
        fire(NE'(5'b00110), 1, NE'(5'b00110), 1'b1);
        chk("R9 clear beats increment", 64'(act_cnt), 64'(0));

        // R5: disabled detectors stay silent and do not count
        fire(NE'(5'b00011), 2, NE'(5'b00011), 1'b0);
        det_en = 1'b0;
        fire('1, 0, '0, 1'b0);
        fire('1, 3, '0, 1'b0);
        det_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5 nothing stale after enable", 64'(act_vec), 64'(0));
            chk("R5 count held", 64'(act_cnt), 64'(cnt_model));
        end
        fire(NE'(5'b10000), 0, NE'(5'b10000), 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule